// File: doc/BRIEF.md
# Paged Data-Space Address Extender

This block widens a 16-bit effective data address into a 24-bit extended address. When the top bit of the effective address is clear, the access stays in the plain 16-bit data space. When it is set, the lower 15 bits are combined with a page number from one of two page registers: one for reads and one for writes. The read page has one extra top bit. When that bit is set, a paged read is redirected to a program-space-visibility window. The block only flags that request; it does not build the address for it.

A host writes both page registers and reads them back through a small register port. A data path presents one access per cycle with a valid strobe, a direction bit and the address. The block returns the final address and flags for an extended access and for a visibility request, all in the same cycle. A paged read with a read page of zero is a fault. In that case the block raises a one-cycle trap pulse in that cycle.

Top module: `page_addr_extender`

## Requirements
- R1: After reset the read page holds 0x001 and the write page holds 0x001.
- R2: `cfg_sel` = 0 addresses the 10-bit read page and `cfg_sel` = 1 addresses the 9-bit write page. Write data bits above a register's width are dropped, and `cfg_rdata` returns the selected page zero-extended to 16 bits.
- R3: A valid access with address bit 15 = 0 outputs the address zero-extended to 24 bits, with `ext_flag`, `vis_flag` and `trap` low, whatever the page values are.
- R4: A valid read with address bit 15 = 1 and read-page bit 9 = 0 outputs {read page bits 8:0, address bits 14:0} with `ext_flag` high and `vis_flag` low.
- R5: A valid read with address bit 15 = 1 and read-page bit 9 = 1 raises `vis_flag`, keeps `ext_flag` and `trap` low, and outputs address bits 14:0 with the upper 9 bits zero.
- R6: A valid write with address bit 15 = 1 outputs {write page bits 8:0, address bits 14:0} with `ext_flag` high and `trap` low, whatever the read page holds.
- R7: A valid read with address bit 15 = 1 and the read page equal to 0x000 raises `trap` in that same cycle, together with `ext_flag`. `trap` is never high otherwise.
- R8: A page write takes effect at the next clock edge. An access in the same cycle as the write uses the old page value.
- R9: While `acc_valid` is low, `ext_flag`, `vis_flag` and `trap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Page register write strobe |
| cfg_sel | input | 1 | Register select: 0 read page, 1 write page |
| cfg_wdata | input | 16 | Page register write data |
| cfg_rdata | output | 16 | Selected page register, zero-extended |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | Access direction: 1 write, 0 read |
| acc_addr | input | 16 | Effective data address |
| ext_addr | output | 24 | Resulting address |
| ext_flag | output | 1 | Extended (paged) data access |
| vis_flag | output | 1 | Program-space-visibility request |
| trap | output | 1 | Address-error pulse for a zero read page |

## Verification
The assertions check the address mapping on every cycle against the held page values. This covers plain, paged-read, visibility and paged-write accesses, and the trap condition in both directions. They also check that the flags stay quiet without a strobe and that a page write lands one edge later. Only the bench scenarios show the things the assertions cannot see: write data truncated at the register port and returned through readback, and the ordering case where a page write and an access share one cycle. The bench's sweep over page values and addresses shows the mapping across page bit patterns, including the zero page and the visibility pages.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    parameter int EA_W    = 16;
    parameter int XA_W    = 24;
    parameter int RPG_W   = 10;
    parameter int WPG_W   = 9;
    parameter int CFG_W   = 16;

    localparam int LOW_W  = EA_W - 1;
    localparam int PG_LOW = XA_W - LOW_W;

    localparam logic [RPG_W-1:0] RPG_RST = RPG_W'(1);
    localparam logic [WPG_W-1:0] WPG_RST = WPG_W'(1);

    typedef enum logic [1:0] {
        MAP_PLAIN = 2'd0,
        MAP_EXT   = 2'd1,
        MAP_VIS   = 2'd2
    } map_kind_t;

    typedef enum logic {
        SEL_RPAGE = 1'b0,
        SEL_WPAGE = 1'b1
    } page_sel_t;

    typedef struct packed {
        logic [XA_W-1:0] addr;
        map_kind_t       kind;
        logic            fault;
    } map_res_t;

    function automatic logic [XA_W-1:0] widen_ea(input logic [EA_W-1:0] ea);
        return XA_W'(ea);
    endfunction

    function automatic logic [XA_W-1:0] join_page(input logic [PG_LOW-1:0] pg,
                                                  input logic [LOW_W-1:0]  low);
        return {pg, low};
    endfunction

endpackage

// File: rtl/pgx_page_reg.sv
module pgx_page_reg
    import pgx_pkg::*;
#(
    parameter int              W       = 10,
    parameter logic [W-1:0]    RST_VAL = W'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [W-1:0]     q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= wdata[W-1:0];
        end
    end

endmodule

// File: rtl/pgx_map.sv
module pgx_map
    import pgx_pkg::*;
(
    input  logic             is_write,
    input  logic [EA_W-1:0]  ea,
    input  logic [RPG_W-1:0] rpg,
    input  logic [WPG_W-1:0] wpg,
    output map_res_t         res
);

    logic             paged;
    logic [LOW_W-1:0] low;
    logic             vis_sel;
    logic             rpg_zero;

    assign paged    = ea[EA_W-1];
    assign low      = ea[LOW_W-1:0];
    assign vis_sel  = rpg[RPG_W-1];
    assign rpg_zero = (rpg == '0);

    always_comb begin
        res.addr  = widen_ea(ea);
        res.kind  = MAP_PLAIN;
        res.fault = 1'b0;
        if (paged) begin
            if (is_write) begin
                res.addr = join_page(wpg[PG_LOW-1:0], low);
                res.kind = MAP_EXT;
            end else if (vis_sel) begin
                res.addr = XA_W'(low);
                res.kind = MAP_VIS;
            end else begin
                res.addr  = join_page(rpg[PG_LOW-1:0], low);
                res.kind  = MAP_EXT;
                res.fault = rpg_zero;
            end
        end
    end

endmodule

// File: rtl/page_addr_extender.sv
module page_addr_extender
    import pgx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [EA_W-1:0]  acc_addr,
    output logic [XA_W-1:0]  ext_addr,
    output logic             ext_flag,
    output logic             vis_flag,
    output logic             trap
);

    logic [RPG_W-1:0] rd_page;
    logic [WPG_W-1:0] wr_page;
    logic             rd_we;
    logic             wr_we;
    map_res_t         mres;

    assign rd_we = cfg_wr && (page_sel_t'(cfg_sel) == SEL_RPAGE);
    assign wr_we = cfg_wr && (page_sel_t'(cfg_sel) == SEL_WPAGE);

    pgx_page_reg #(.W(RPG_W), .RST_VAL(RPG_RST)) u_rpage (
        .clk   (clk),
        .rst   (rst),
        .we    (rd_we),
        .wdata (cfg_wdata),
        .q     (rd_page)
    );

    pgx_page_reg #(.W(WPG_W), .RST_VAL(WPG_RST)) u_wpage (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_we),
        .wdata (cfg_wdata),
        .q     (wr_page)
    );

    always_comb begin
        if (page_sel_t'(cfg_sel) == SEL_RPAGE) begin
            cfg_rdata = CFG_W'(rd_page);
        end else begin
            cfg_rdata = CFG_W'(wr_page);
        end
    end

    pgx_map u_map (
        .is_write (acc_write),
        .ea       (acc_addr),
        .rpg      (rd_page),
        .wpg      (wr_page),
        .res      (mres)
    );

    assign ext_addr = mres.addr;
    assign ext_flag = acc_valid && (mres.kind == MAP_EXT);
    assign vis_flag = acc_valid && (mres.kind == MAP_VIS);
    assign trap     = acc_valid && mres.fault;

endmodule

// File: rtl/pgx_chk.sv
module pgx_chk
    import pgx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic             cfg_sel,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             acc_valid,
    input logic             acc_write,
    input logic [EA_W-1:0]  acc_addr,
    input logic [XA_W-1:0]  ext_addr,
    input logic             ext_flag,
    input logic             vis_flag,
    input logic             trap,
    input logic [RPG_W-1:0] rd_page,
    input logic [WPG_W-1:0] wr_page
);

    logic [LOW_W-1:0] low;
    logic             hi;
    assign low = acc_addr[LOW_W-1:0];
    assign hi  = acc_addr[EA_W-1];

    a_r1_reset_pages: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_page == RPG_RST) && (wr_page == WPG_RST));

    a_r3_plain_access: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !hi) |->
            (ext_addr == XA_W'(acc_addr)) && !ext_flag && !vis_flag && !trap);

    a_r4_paged_read: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && hi && !rd_page[RPG_W-1]) |->
            (ext_addr == {rd_page[PG_LOW-1:0], low}) && ext_flag && !vis_flag);

    a_r5_vis_read: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && hi && rd_page[RPG_W-1]) |->
            vis_flag && !ext_flag && !trap && (ext_addr == XA_W'(low)));

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_flag, vis_flag}));

    a_r6_paged_write: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && hi) |->
            (ext_addr == {wr_page[PG_LOW-1:0], low}) && ext_flag && !trap);

    a_r7_trap_cause: assert property (@(posedge clk) disable iff (rst)
        trap |-> acc_valid && !acc_write && hi && (rd_page == '0) && ext_flag);

    a_r7_trap_raised: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && hi && (rd_page == '0)) |-> trap);

    a_r8_rpage_update: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_wr && !cfg_sel) |-> (rd_page == $past(cfg_wdata[RPG_W-1:0])));

    a_r8_wpage_update: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_wr && cfg_sel) |-> (wr_page == $past(cfg_wdata[WPG_W-1:0])));

    a_r8_rpage_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_wr && !cfg_sel)) |-> $stable(rd_page));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !ext_flag && !vis_flag && !trap);

endmodule

bind page_addr_extender pgx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .ext_addr  (ext_addr),
    .ext_flag  (ext_flag),
    .vis_flag  (vis_flag),
    .trap      (trap),
    .rd_page   (rd_page),
    .wr_page   (wr_page)
);

// File: tb/page_addr_extender_tb.sv
module page_addr_extender_tb;

    localparam int PERIOD = 10;
    localparam int WDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [23:0] ext_addr;
    logic        ext_flag;
    logic        vis_flag;
    logic        trap;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [9:0] m_rpg;
    logic [8:0] m_wpg;

    always #(PERIOD/2) clk = ~clk;

    page_addr_extender u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .ext_addr(ext_addr), .ext_flag(ext_flag), .vis_flag(vis_flag), .trap(trap)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected result {addr, ext, vis, trap} from the requirements
    task automatic access_chk(input string req, input bit v, input bit w, input logic [15:0] a,
                              input logic [9:0] rp, input logic [8:0] wp);
        logic [23:0] ea;
        bit e, s, t;
        ea = {8'h00, a}; e = 0; s = 0; t = 0;
        if (a[15]) begin
            if (w) begin
                ea = {wp, a[14:0]}; e = 1;
            end else if (rp[9]) begin
                ea = {9'h000, a[14:0]}; s = 1;
            end else begin
                ea = {rp[8:0], a[14:0]}; e = 1; t = (rp == 10'h000);
            end
        end
        if (!v) begin e = 0; s = 0; t = 0; end
        if (v) check(req, {8'h00, ext_addr}, {8'h00, ea});
        check(req, {29'h0, ext_flag, vis_flag, trap}, {29'h0, e, s, t});
    endtask

    task automatic do_access(input string req, input bit v, input bit w, input logic [15:0] a);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_addr = a;
        #1;
        access_chk(req, v, w, a, m_rpg, m_wpg);
    endtask

    task automatic write_page(input bit sel, input logic [15:0] d);
        @(negedge clk);
        acc_valid = 0;
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
        if (sel) m_wpg = d[8:0]; else m_rpg = d[9:0];
    endtask

    task automatic read_page(input string req, input bit sel, input logic [15:0] exp);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        check(req, {16'h0, cfg_rdata}, {16'h0, exp});
    endtask

    initial begin : wdog
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [9:0]  rpl [8];
        logic [8:0]  wpl [3];
        logic [15:0] ad;
        rpl = '{10'h000, 10'h001, 10'h0AA, 10'h155, 10'h1FF, 10'h200, 10'h2AB, 10'h3FF};
        wpl = '{9'h000, 9'h1FF, 9'h0A5};
        m_rpg = 10'h001; m_wpg = 9'h001;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset values
        read_page("R1", 1'b0, 16'h0001);
        read_page("R1", 1'b1, 16'h0001);
        do_access("R1", 1, 0, 16'h8000);

        // R2 truncation and readback
        write_page(1'b0, 16'hFC00 | 16'h0155);
        read_page("R2", 1'b0, 16'h0155);
        write_page(1'b1, 16'hFE00 | 16'h00A5);
        read_page("R2", 1'b1, 16'h00A5);
        read_page("R2", 1'b0, 16'h0155);

        // R3..R7, R9 sweep
        for (int p = 0; p < 8; p++) begin
            write_page(1'b0, {6'h3F, rpl[p]});
            for (int q = 0; q < 3; q++) begin
                write_page(1'b1, {7'h7F, wpl[q]});
                for (int i = 0; i < 68; i++) begin
                    if (i < 64) ad = 16'(i * 1031);
                    else if (i == 64) ad = 16'h0000;
                    else if (i == 65) ad = 16'h7FFF;
                    else if (i == 66) ad = 16'h8000;
                    else ad = 16'hFFFF;
                    do_access(ad[15] ? (rpl[p] == 0 ? "R7" : (rpl[p][9] ? "R5" : "R4")) : "R3",
                              1, 0, ad);
                    do_access(ad[15] ? "R6" : "R3", 1, 1, ad);
                    do_access("R9", 0, i[0], ad);
                end
            end
        end

        // R7 explicit zero-page trap, write unaffected
        write_page(1'b0, 16'h0000);
        do_access("R7", 1, 0, 16'hC123);
        check("R7", {31'h0, trap}, 32'h1);
        do_access("R6", 1, 1, 16'hC123);
        check("R6", {31'h0, trap}, 32'h0);

        // R8 same-cycle access sees the old page
        write_page(1'b0, 16'h0012);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = 0; cfg_wdata = 16'h0034;
        acc_valid = 1; acc_write = 0; acc_addr = 16'h8ABC;
        #1;
        check("R8", {8'h0, ext_addr}, {8'h0, 9'h012, 15'h0ABC});
        @(negedge clk);
        cfg_wr = 0; m_rpg = 10'h034;
        #1;
        check("R8", {8'h0, ext_addr}, {8'h0, 9'h034, 15'h0ABC});
        access_chk("R8", 1, 0, 16'h8ABC, m_rpg, m_wpg);

        @(negedge clk);
        acc_valid = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule